// File: doc/BRIEF.md
# 8-bit Host Bus Master Sequencer

This block converts single read and write requests from an internal request port into cycles on an 8-bit parallel host bus, for slaves such as SRAM, flash, or a programmable-logic device. A request is accepted only while the sequencer is idle. Each access runs as an optional address phase followed by a data phase. During the data phase the read or write strobe is asserted for a programmed number of clocks. A read response is returned on a one-cycle valid pulse.

Two bus formats are supported. In the shared format, the low address byte is driven on the same eight pins that later carry data, and an address-latch strobe qualifies it for one clock. In the split format, the full address has its own pins and the data phase starts at once. The polarity of each strobe can be set independently. Read and write wait-state codes are separate. An optional ready input, whose polarity can be selected, stretches the data phase.

The configuration inputs are copied into an internal snapshot on every clock while the sequencer is idle. They are held constant for the duration of an access.

Top module: `hbm_seq_top`

## Requirements
- R1: After reset the sequencer is in the following state. busy=0, rsp_valid=0 and bus_ad_oe=0. The snapshot holds write and read polarity 0 (active low) and ALE polarity 1 (active high). So bus_rd=1, bus_wr=1 and bus_ale=0.
- R2: req_valid is sampled on a rising clock edge while busy=0. If it is high, the request is accepted and busy is high from the next cycle until the access completes. A req_valid that arrives while busy=1 is ignored: it starts no access and does not change bus_addr.
- R3: Sub-mode code 0 selects the shared format. The access opens with exactly one address clock, in which ALE is active, bus_ad_o equals req_addr[7:0] and bus_ad_oe=1. No strobe is active in that clock. The data phase follows, with ALE inactive.
- R4: Any non-zero sub-mode code selects the split format. ALE is never active, and the data phase begins in the cycle right after acceptance.
- R5: With no stall, the write strobe stays active for 2*(code+1) clocks of the write wait-state code. Throughout that time bus_ad_o carries the write data and bus_ad_oe=1. The read wait-state code has no effect on writes.
- R6: With no stall, the read strobe stays active for 2*(code+1) clocks of the read wait-state code. bus_ad_oe=0 throughout the read data phase. The write wait-state code has no effect on reads.
- R7: Strobe polarity is set by a bit per strobe: 0 means active low and 1 means active high. Between accesses each strobe rests at its inactive level. A polarity change made while idle reaches the pin after one clock.
- R8: The ALE polarity bit gives an active-high latch strobe when it is 1 and an active-low latch strobe when it is 0.
- R9: Take ready-enable set. If ready-invert is 0, each data-phase edge that sees bus_rdy=0 lengthens the strobe by one clock. If ready-invert is 1, the same happens for each such edge that sees bus_rdy=1.
- R10: With ready-enable clear, bus_rdy has no effect on strobe width.
- R11: Read data is sampled from bus_ad_i on the edge at which the read strobe is released. On that same edge rsp_valid rises and busy falls. rsp_valid stays high for exactly one cycle and never pulses for writes.
- R12: bus_addr carries the full accepted address for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus clock per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_submode | input | 2 | Bus format: 0 shared, others split |
| cfg_wr_ws | input | 2 | Write wait-state code |
| cfg_rd_ws | input | 2 | Read wait-state code |
| cfg_wr_pol | input | 1 | Write strobe active level |
| cfg_rd_pol | input | 1 | Read strobe active level |
| cfg_ale_pol | input | 1 | Address-latch strobe active level |
| cfg_rdy_en | input | 1 | Enable ready-based stalling |
| cfg_rdy_inv | input | 1 | Stall on high ready instead of low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Address pins |
| bus_ad_o | output | DATA_W | Shared address/data pins, outbound |
| bus_ad_i | input | DATA_W | Shared address/data pins, inbound |
| bus_ad_oe | output | 1 | Output enable for bus_ad_o |
| bus_ale | output | 1 | Address-latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdy | input | 1 | External ready |

## Verification
The assertions assume that bus_rdy and bus_ad_i are synchronous to clk and settle before the sampling edge. They also assume a pending request is not withdrawn from the request port in the same cycle it is raised. The bench meets these conditions by changing every input only on the falling clock edge. It holds bus_ad_i constant for the whole access, and it pulses req_valid during a busy period only at a point where the strobe cannot end on the next edge.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
  localparam int HBM_WS_W = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  typedef struct packed {
    logic                muxed;
    logic [HBM_WS_W-1:0] wr_ws;
    logic [HBM_WS_W-1:0] rd_ws;
    logic                wr_pol;
    logic                rd_pol;
    logic                ale_pol;
    logic                rdy_en;
    logic                rdy_inv;
  } bus_cfg_t;

  localparam bus_cfg_t CFG_RST = '{
    muxed:   1'b0,
    wr_ws:   '0,
    rd_ws:   '0,
    wr_pol:  1'b0,
    rd_pol:  1'b0,
    ale_pol: 1'b1,
    rdy_en:  1'b0,
    rdy_inv: 1'b0
  };
endpackage

// File: rtl/hbm_cfg_latch.sv
module hbm_cfg_latch
  import hbm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load_en,
  input  bus_cfg_t cfg_in,
  output bus_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)          cfg_q <= CFG_RST;
    else if (load_en) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/hbm_phase_ctr.sv
module hbm_phase_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/hbm_pin_drv.sv
module hbm_pin_drv #(
  parameter int DATA_W = 8,
  parameter int NSTB   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSTB-1:0]   act_nx,
  input  logic [NSTB-1:0]   pol,
  input  logic              oe_nx,
  input  logic [DATA_W-1:0] ad_nx,
  output logic [NSTB-1:0]   act_q,
  output logic [NSTB-1:0]   pin,
  output logic              oe_q,
  output logic [DATA_W-1:0] ad_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      oe_q  <= 1'b0;
      ad_q  <= '0;
    end else begin
      act_q <= act_nx;
      oe_q  <= oe_nx;
      ad_q  <= ad_nx;
    end
  end

  for (genvar g = 0; g < NSTB; g++) begin : g_pol
    assign pin[g] = act_q[g] ~^ pol[g];
  end
endmodule

// File: rtl/hbm_seq_top.sv
module hbm_seq_top
  import hbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_submode,
  input  logic [HBM_WS_W-1:0] cfg_wr_ws,
  input  logic [HBM_WS_W-1:0] cfg_rd_ws,
  input  logic                cfg_wr_pol,
  input  logic                cfg_rd_pol,
  input  logic                cfg_ale_pol,
  input  logic                cfg_rdy_en,
  input  logic                cfg_rdy_inv,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                busy,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_ad_o,
  input  logic [DATA_W-1:0]   bus_ad_i,
  output logic                bus_ad_oe,
  output logic                bus_ale,
  output logic                bus_rd,
  output logic                bus_wr,
  input  logic                bus_rdy
);
  localparam int CNT_W = HBM_WS_W + 1;
  localparam int NSTB  = 3;
  localparam int S_ALE = 2;
  localparam int S_RD  = 1;
  localparam int S_WR  = 0;

  phase_e            ph_q, ph_d;
  bus_cfg_t          cfg_in, cfg_q, cfg_sel;
  logic              wr_q, write_d, accept, finish, stall;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [ADDR_W-1:0] addr_d;
  logic              ctr_load, ctr_dec, ctr_zero;
  logic [CNT_W-1:0]  ctr_val;
  logic [HBM_WS_W-1:0] ws_sel;
  logic [NSTB-1:0]   act_nx, act_q, pol, pins;
  logic              oe_nx;
  logic [DATA_W-1:0] ad_nx;

  assign cfg_in = '{
    muxed:   (cfg_submode == 2'd0),
    wr_ws:   cfg_wr_ws,
    rd_ws:   cfg_rd_ws,
    wr_pol:  cfg_wr_pol,
    rd_pol:  cfg_rd_pol,
    ale_pol: cfg_ale_pol,
    rdy_en:  cfg_rdy_en,
    rdy_inv: cfg_rdy_inv
  };

  // Snapshot follows the inputs while idle, frozen during an access
  hbm_cfg_latch u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load_en (ph_q == PH_IDLE),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg_q)
  );

  // At acceptance the snapshot is not yet loaded: use the live inputs
  assign cfg_sel = (ph_q == PH_IDLE) ? cfg_in : cfg_q;
  assign write_d = accept ? req_write : wr_q;
  assign wdata_d = accept ? req_wdata : wdata_q;
  assign addr_d  = accept ? req_addr  : bus_addr;
  assign ws_sel  = write_d ? cfg_sel.wr_ws : cfg_sel.rd_ws;
  assign ctr_val = {ws_sel, 1'b1};
  assign stall   = cfg_q.rdy_en & ~(bus_rdy ^ cfg_q.rdy_inv);

  always_comb begin
    ph_d     = ph_q;
    accept   = 1'b0;
    finish   = 1'b0;
    ctr_load = 1'b0;
    ctr_dec  = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          ph_d     = cfg_in.muxed ? PH_ADDR : PH_DATA;
          ctr_load = ~cfg_in.muxed;
        end
      end
      PH_ADDR: begin
        ph_d     = PH_DATA;
        ctr_load = 1'b1;
      end
      PH_DATA: begin
        if (!stall) begin
          if (ctr_zero) begin
            finish = 1'b1;
            ph_d   = PH_IDLE;
          end else begin
            ctr_dec = 1'b1;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  hbm_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (ctr_load),
    .load_val (ctr_val),
    .dec      (ctr_dec),
    .zero     (ctr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      bus_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      ph_q      <= ph_d;
      rsp_valid <= finish & ~wr_q;
      if (accept) begin
        wr_q     <= req_write;
        wdata_q  <= req_wdata;
        bus_addr <= req_addr;
      end
      if (finish && !wr_q) rsp_rdata <= bus_ad_i;
    end
  end

  assign busy = (ph_q != PH_IDLE);

  // Logical (active-true) strobe intents for the next cycle
  assign act_nx[S_ALE] = (ph_d == PH_ADDR);
  assign act_nx[S_RD]  = (ph_d == PH_DATA) & ~write_d;
  assign act_nx[S_WR]  = (ph_d == PH_DATA) &  write_d;
  assign oe_nx         = (ph_d == PH_ADDR) | ((ph_d == PH_DATA) & write_d);
  assign ad_nx         = (ph_d == PH_ADDR) ? addr_d[DATA_W-1:0] : wdata_d;

  assign pol[S_ALE] = cfg_q.ale_pol;
  assign pol[S_RD]  = cfg_q.rd_pol;
  assign pol[S_WR]  = cfg_q.wr_pol;

  hbm_pin_drv #(.DATA_W(DATA_W), .NSTB(NSTB)) u_pins (
    .clk    (clk),
    .rst    (rst),
    .act_nx (act_nx),
    .pol    (pol),
    .oe_nx  (oe_nx),
    .ad_nx  (ad_nx),
    .act_q  (act_q),
    .pin    (pins),
    .oe_q   (bus_ad_oe),
    .ad_q   (bus_ad_o)
  );

  assign bus_ale = pins[S_ALE];
  assign bus_rd  = pins[S_RD];
  assign bus_wr  = pins[S_WR];

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> busy);
  // R3
  ale_excl_chk: assert property (@(posedge clk) disable iff (rst)
    act_q[S_ALE] |-> !(act_q[S_RD] || act_q[S_WR]));
  // R6
  rd_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    act_q[S_RD] |-> !bus_ad_oe);
  // R4
  split_no_ale_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && cfg_submode != 2'd0) |=> !act_q[S_ALE]);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_DATA && stall) |=> (busy && $stable(act_q)));
  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R11
  rsp_at_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q[S_RD]) |-> (rsp_valid && !busy));
endmodule

// File: tb/hbm_seq_top_tb.sv
`timescale 1ns/1ps
module hbm_seq_top_tb_top;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_submode = 2'd0;
  logic [1:0] cfg_wr_ws = 2'd0, cfg_rd_ws = 2'd0;
  logic cfg_wr_pol = 1'b0, cfg_rd_pol = 1'b0, cfg_ale_pol = 1'b1;
  logic cfg_rdy_en = 1'b0, cfg_rdy_inv = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, rsp_valid, bus_ad_oe, bus_ale, bus_rd, bus_wr;
  logic [DW-1:0] rsp_rdata, bus_ad_o;
  logic [DW-1:0] bus_ad_i = '0;
  logic [AW-1:0] bus_addr;
  logic bus_rdy = 1'b1;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  hbm_seq_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_submode(cfg_submode), .cfg_wr_ws(cfg_wr_ws), .cfg_rd_ws(cfg_rd_ws),
    .cfg_wr_pol(cfg_wr_pol), .cfg_rd_pol(cfg_rd_pol), .cfg_ale_pol(cfg_ale_pol),
    .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_inv(cfg_rdy_inv),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_ad_o(bus_ad_o),
    .bus_ad_i(bus_ad_i), .bus_ad_oe(bus_ad_oe), .bus_ale(bus_ale),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdy(bus_rdy)
  );

  typedef struct packed {
    logic [1:0]    sub;
    logic          wr;
    logic [1:0]    ws;
    logic          wpol;
    logic          rpol;
    logic          apol;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 16'h1234, 8'hA5},
    '{2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 16'hBEEF, 8'h3C},
    '{2'd1, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 16'h0F0F, 8'h81},
    '{2'd1, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 16'hC0DE, 8'h7E},
    '{2'd0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 16'h5AA5, 8'hFF},
    '{2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 16'h00FF, 8'h00},
    '{2'd3, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 16'hFFFF, 8'h55},
    '{2'd2, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 16'h8001, 8'hC3}
  };

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access; the width seen is compared with exp_w
  task automatic run_acc(input vec_t v, input logic ren, input logic rinv,
                         input int hold_n, input logic rdy_start,
                         input bit poke, input int exp_w);
    logic go;
    int   width, nale, guard;
    bit   addr_bad, ale_bad, dat_bad, excl_bad, ord_bad;
    bit   mux, ale_a, rd_a, wr_a, stb_a, oth_a;
    go = ~rinv;
    width = 0; nale = 0; guard = 0;
    addr_bad = 0; ale_bad = 0; dat_bad = 0; excl_bad = 0; ord_bad = 0;
    mux = (v.sub == 2'd0);
    @(negedge clk);
    cfg_submode = v.sub;
    cfg_wr_ws   = v.wr ? v.ws : 2'd3 - v.ws;
    cfg_rd_ws   = v.wr ? 2'd3 - v.ws : v.ws;
    cfg_wr_pol  = v.wpol;
    cfg_rd_pol  = v.rpol;
    cfg_ale_pol = v.apol;
    cfg_rdy_en  = ren;
    cfg_rdy_inv = rinv;
    bus_rdy     = rdy_start;
    req_valid   = 1'b1;
    req_write   = v.wr;
    req_addr    = v.addr;
    req_wdata   = v.data;
    bus_ad_i    = v.wr ? ~v.data : v.data;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    while (busy && guard < 200) begin
      guard++;
      ale_a = (bus_ale == v.apol);
      rd_a  = (bus_rd == v.rpol);
      wr_a  = (bus_wr == v.wpol);
      stb_a = v.wr ? wr_a : rd_a;
      oth_a = v.wr ? rd_a : wr_a;
      if (bus_addr != v.addr) addr_bad = 1;
      if (oth_a) excl_bad = 1;
      if (ale_a) begin
        nale++;
        if (bus_ad_o != v.addr[DW-1:0] || !bus_ad_oe) ale_bad = 1;
        if (stb_a || width > 0) ord_bad = 1;
      end
      if (stb_a) begin
        width++;
        if (mux && nale == 0) ord_bad = 1;
        if (v.wr && (!bus_ad_oe || bus_ad_o != v.data)) dat_bad = 1;
        if (!v.wr && bus_ad_oe) dat_bad = 1;
      end
      if (poke && width == 2) begin
        req_valid = 1'b1;
        req_addr  = ~v.addr;
      end else begin
        req_valid = 1'b0;
      end
      if (hold_n > 0 && width == hold_n) bus_rdy = go;
      @(negedge clk);
    end
    req_valid = 1'b0;
    req_addr  = v.addr;
    chk(width == exp_w, v.wr ? "R5/R9 write strobe width" : "R6/R9 read strobe width",
        width, exp_w);
    chk(nale == (mux ? 1 : 0), mux ? "R3 one address clock" : "R4 no address clock",
        nale, mux ? 1 : 0);
    chk(!ale_bad && !ord_bad, "R3 address phase content and order", {ale_bad, ord_bad}, 0);
    chk(!dat_bad, v.wr ? "R5 write data driven" : "R6 read pins released", dat_bad, 0);
    chk(!excl_bad, "R7 other strobe idle", excl_bad, 0);
    chk(!addr_bad, "R12 address held", addr_bad, 0);
    if (v.wr)
      chk(rsp_valid == 1'b0, "R11 no response on write", rsp_valid, 0);
    else
      chk(rsp_valid && rsp_rdata == v.data, "R11 read data at release",
          {rsp_valid, rsp_rdata}, {1'b1, v.data});
    chk(bus_rd == ~v.rpol && bus_wr == ~v.wpol && bus_ale == ~v.apol && !bus_ad_oe,
        "R7 R8 idle levels", {bus_ale, bus_rd, bus_wr, bus_ad_oe},
        {~v.apol, ~v.rpol, ~v.wpol, 1'b0});
    @(negedge clk);
    chk(!rsp_valid && !busy, poke ? "R2 busy request ignored" : "R11 single pulse",
        {rsp_valid, busy}, 0);
    bus_rdy = 1'b1;
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!busy && !rsp_valid && !bus_ad_oe, "R1 reset outputs",
        {busy, rsp_valid, bus_ad_oe}, 0);
    chk(bus_ale == 1'b0 && bus_rd == 1'b1 && bus_wr == 1'b1, "R1 reset strobe levels",
        {bus_ale, bus_rd, bus_wr}, 3'b011);

    for (int i = 0; i < NV; i++)
      run_acc(VECS[i], 1'b0, 1'b0, 0, 1'b1, 1'b0, 2 * (VECS[i].ws + 1));

    // R10 ready low but enable clear
    d = '{2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 16'h4242, 8'h96};
    run_acc(d, 1'b0, 1'b0, 0, 1'b0, 1'b0, 4);
    // R9 stall on low ready: 3 stalled edges
    d = '{2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 16'h7788, 8'h4D};
    run_acc(d, 1'b1, 1'b0, 4, 1'b0, 1'b0, 4 + 3);
    // R9 inverted ready: stall while high, 2 stalled edges
    d = '{2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 16'h9911, 8'hE1};
    run_acc(d, 1'b1, 1'b1, 3, 1'b1, 1'b0, 2 + 2);
    // R2 request pulsed mid-access
    d = '{2'd1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 16'h3355, 8'h2B};
    run_acc(d, 1'b0, 1'b0, 0, 1'b1, 1'b1, 6);

    // R7 idle polarity change reaches pin after one clock
    @(negedge clk);
    cfg_wr_pol = 1'b0;
    cfg_ale_pol = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(bus_wr == 1'b1, "R7 idle write level active-low", bus_wr, 1);
    cfg_wr_pol = 1'b1;
    cfg_ale_pol = 1'b0;
    @(negedge clk);
    chk(bus_wr == 1'b0, "R7 idle write level active-high", bus_wr, 0);
    chk(bus_ale == 1'b1, "R8 idle ALE level active-low", bus_ale, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule